// File: doc/BRIEF.md
# SDRAM Column Data Path with Byte Masking

This block is the data-side pipeline that sits next to an SDRAM command issuer. The issuer raises one strobe in the cycle it registers a READ, WRITE or burst-stop command onto the pads. The block registers write data, the byte mask and the DQ output enable onto the pads in that same cycle. Read data comes back a programmable CAS latency later, and the block captures it on that edge.

Byte masks behave differently in the two directions. On a write the mask travels with the data beat. On a read the memory applies the mask it registered two clocks before the data it gates, so the block delays the mask it drove to mark each captured byte valid or masked. Bursts of 1, 2, 4, 8 beats or a full page are tracked beat by beat. A new column command can arrive on any clock and restart the burst, and a burst stop ends the burst.

An edge "k" below is the rising clock edge at which an input is sampled. CL is 2 when `cfg_cl3` is low and 3 when it is high.

Top module: `sdram_dq_path`

## Requirements
- R1: While reset is held and after it is released, `dq_oe`, `dq_out`, `dqm_out`, `rd_valid`, `rd_byte_vld` and `wr_take` are all zero.
- R2: A write beat sampled at edge k raises `wr_take` in the cycle before edge k. After edge k, `dq_out` equals the sampled `wr_data_in`, `dqm_out` equals the sampled `wr_mask_in` and `dq_oe` is high.
- R3: `cfg_bl`, sampled with the command, sets the beat count on consecutive edges: code 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, codes 4 to 6 give 1, and code 7 (full page) continues until the burst is stopped or replaced.
- R4: A read beat sampled at edge k is captured from `dq_in` at edge k+1+CL. After that edge `rd_valid` is high for one cycle and `rd_data` holds the captured word.
- R5: `cfg_cl3` low selects a CAS latency of 2 clocks and high selects 3.
- R6: A capture at edge e uses the `dqm_out` value set at edge e-3. A byte whose mask bit is 1 has its `rd_byte_vld` bit at 0 and its `rd_data` byte at zero. `rd_byte_vld` is all zero whenever `rd_valid` is low.
- R7: Mask bit i governs data bits 8i+7 down to 8i, in both the read and the write direction.
- R8: `cmd_bst` ends the current burst. No beat occurs at that edge or afterwards until the next READ or WRITE. Read beats already issued still return.
- R9: A READ or WRITE may be sampled on any edge. It ends the burst in progress and starts a new one at that edge.
- R10: `dq_oe` is high only after a write beat. When the issuer separates a write from earlier reads, `dq_oe` is never high during a cycle whose closing edge captures read data.
- R11: On any edge without a write beat, `dqm_out` takes the sampled `rd_mask_in`, `dq_oe` drops and `dq_out` goes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cl3 | input | 1 | CAS latency select: 0 gives 2, 1 gives 3 |
| cfg_bl | input | 3 | Burst length code |
| cmd_rd | input | 1 | READ issued this cycle |
| cmd_wr | input | 1 | WRITE issued this cycle |
| cmd_bst | input | 1 | Burst stop issued this cycle |
| wr_data_in | input | DW | Write data for the current beat |
| wr_mask_in | input | DW/8 | Write byte mask for the current beat, 1 blocks the byte |
| wr_take | output | 1 | The current cycle is a write beat and consumes wr_data_in |
| rd_mask_in | input | DW/8 | Read byte mask to drive on cycles without a write beat |
| dq_out | output | DW | Data toward the DQ pads |
| dq_oe | output | 1 | DQ pad output enable |
| dqm_out | output | DW/8 | Byte mask toward the pads |
| dq_in | input | DW | Data from the DQ pads |
| rd_valid | output | 1 | Captured read word is present |
| rd_data | output | DW | Captured read word, masked bytes zero |
| rd_byte_vld | output | DW/8 | Per-byte validity of rd_data |

## Verification
The bench aims at the two different mask latencies. A design that used the read mask at the capture edge, or one edge early, would flag the wrong bytes whenever the mask changes from beat to beat, and the bench changes it on every beat. It switches CAS latency between phases, so a capture tap that is one stage off shows data from the wrong edge. It also covers a burst stop in mid-burst, a new command on every edge, a full-page burst that must keep going and the reserved length codes. A counter that miscounts, ignores the stop or fails to restart shows up as extra or missing beats on `wr_take` and `rd_valid`.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

  localparam int unsigned MAX_BEATS = 8;
  localparam int unsigned BEAT_W    = $clog2(MAX_BEATS) + 1;

  localparam logic [2:0] BLC_1    = 3'd0;
  localparam logic [2:0] BLC_2    = 3'd1;
  localparam logic [2:0] BLC_4    = 3'd2;
  localparam logic [2:0] BLC_8    = 3'd3;
  localparam logic [2:0] BLC_PAGE = 3'd7;

  typedef logic [BEAT_W-1:0] beat_cnt_t;

  // Beat count for a fixed-length code; reserved codes and page give one.
  function automatic beat_cnt_t bl_beats(input logic [2:0] code);
    case (code)
      BLC_2:   return beat_cnt_t'(2);
      BLC_4:   return beat_cnt_t'(4);
      BLC_8:   return beat_cnt_t'(8);
      default: return beat_cnt_t'(1);
    endcase
  endfunction

endpackage

// File: rtl/sdp_beat_seq.sv
module sdp_beat_seq
  import sdp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] cfg_bl,
  input  logic       cmd_rd,
  input  logic       cmd_wr,
  input  logic       cmd_bst,
  output logic       beat_rd,
  output logic       beat_wr
);

  logic      act_q, act_d;
  logic      wr_q, wr_d;
  logic      page_q, page_d;
  beat_cnt_t rem_q, rem_d;
  beat_cnt_t len;
  logic      new_cmd;
  logic      beat;

  always_comb begin
    new_cmd = cmd_rd | cmd_wr;
    len     = bl_beats(cfg_bl);
    act_d   = act_q;
    wr_d    = wr_q;
    page_d  = page_q;
    rem_d   = rem_q;
    if (new_cmd) begin
      page_d = (cfg_bl == BLC_PAGE);
      rem_d  = len - beat_cnt_t'(1);
      act_d  = page_d || (len > beat_cnt_t'(1));
      wr_d   = cmd_wr;
    end else if (cmd_bst) begin
      act_d = 1'b0;
    end else if (act_q && !page_q) begin
      rem_d = rem_q - beat_cnt_t'(1);
      act_d = (rem_q > beat_cnt_t'(1));
    end
  end

  always_comb begin
    beat    = new_cmd | (act_q & ~cmd_bst);
    beat_wr = beat & (new_cmd ? cmd_wr : wr_q);
    beat_rd = beat & ~beat_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      page_q <= 1'b0;
      rem_q  <= '0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      page_q <= page_d;
      rem_q  <= rem_d;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_rd, cmd_wr, cmd_bst})); // R9

  AST_BST_SILENCES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_bst |=> !((beat_rd || beat_wr) && !cmd_rd && !cmd_wr)); // R8

  AST_SINGLE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_rd || cmd_wr) && cfg_bl == BLC_1) ##1 (!cmd_rd && !cmd_wr)
      |-> (!beat_rd && !beat_wr)); // R3

endmodule

// File: rtl/sdp_pad_drive.sv
module sdp_pad_drive #(
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beat_wr,
  input  logic [DW-1:0] wr_data_in,
  input  logic [NB-1:0] wr_mask_in,
  input  logic [NB-1:0] rd_mask_in,
  output logic [DW-1:0] dq_out,
  output logic [NB-1:0] dqm_out,
  output logic          dq_oe
);

  logic [DW-1:0] dq_q, dq_d;
  logic [NB-1:0] dqm_q, dqm_d;
  logic          oe_q, oe_d;
  logic          dq_en;

  always_comb begin
    dq_en = beat_wr | oe_q;
    dq_d  = beat_wr ? wr_data_in : '0;
    dqm_d = beat_wr ? wr_mask_in : rd_mask_in;
    oe_d  = beat_wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq_q  <= '0;
      dqm_q <= '0;
      oe_q  <= 1'b0;
    end else begin
      if (dq_en) dq_q <= dq_d;
      dqm_q <= dqm_d;
      oe_q  <= oe_d;
    end
  end

  assign dq_out  = dq_q;
  assign dqm_out = dqm_q;
  assign dq_oe   = oe_q;

  AST_WR_MASK_SAME_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    beat_wr |=> (dq_oe && dqm_out == $past(wr_mask_in) && dq_out == $past(wr_data_in))); // R2

  AST_IDLE_MASK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    !beat_wr |=> (!dq_oe && dqm_out == $past(rd_mask_in) && dq_out == '0)); // R11

endmodule

// File: rtl/sdp_rd_capture.sv
module sdp_rd_capture #(
  parameter int DW     = 16,
  parameter int MIN_CL = 2,
  parameter int MAX_CL = 3,
  localparam int NB    = DW / 8,
  localparam int DQM_LAT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cl3,
  input  logic          beat_rd,
  input  logic [NB-1:0] dqm_pad,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [NB-1:0] rd_byte_vld
);

  logic [MAX_CL:0]  slot_q, slot_d;
  logic [NB-1:0]    mp_q [DQM_LAT];
  logic [NB-1:0]    mp_d [DQM_LAT];
  logic             cap_now;
  logic             vld_q, vld_d;
  logic [NB-1:0]    bv_q, bv_d;
  logic [NB-1:0]    mask_use;

  always_comb begin
    slot_d   = {slot_q[MAX_CL-1:0], beat_rd};
    cap_now  = cfg_cl3 ? slot_q[MAX_CL] : slot_q[MIN_CL];
    mp_d[0]  = dqm_pad;
    for (int i = 1; i < DQM_LAT; i++) mp_d[i] = mp_q[i-1];
    mask_use = mp_q[DQM_LAT-1];
    vld_d    = cap_now;
    bv_d     = cap_now ? ~mask_use : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      vld_q  <= 1'b0;
      bv_q   <= '0;
      for (int i = 0; i < DQM_LAT; i++) mp_q[i] <= '0;
    end else begin
      slot_q <= slot_d;
      vld_q  <= vld_d;
      bv_q   <= bv_d;
      for (int i = 0; i < DQM_LAT; i++) mp_q[i] <= mp_d[i];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane_q, lane_d;
    always_comb lane_d = mask_use[b] ? 8'h00 : dq_in[8*b +: 8];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       lane_q <= '0;
      else if (cap_now) lane_q <= lane_d;
    end
    assign rd_data[8*b +: 8] = lane_q;

    AST_MASKED_LANE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_byte_vld[b]) |-> (rd_data[8*b +: 8] == 8'h00)); // R7
  end

  assign rd_valid    = vld_q;
  assign rd_byte_vld = bv_q;

  AST_VLD_ONLY_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_byte_vld == '0)); // R6

  AST_READ_MASK_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_byte_vld == ~$past(dqm_pad, 3))); // R6

endmodule

// File: rtl/sdram_dq_path.sv
module sdram_dq_path
  import sdp_pkg::*;
#(
  parameter int DW = 16,
  localparam int NB = DW / 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_cl3,
  input  logic [2:0]    cfg_bl,
  input  logic          cmd_rd,
  input  logic          cmd_wr,
  input  logic          cmd_bst,
  input  logic [DW-1:0] wr_data_in,
  input  logic [NB-1:0] wr_mask_in,
  output logic          wr_take,
  input  logic [NB-1:0] rd_mask_in,
  output logic [DW-1:0] dq_out,
  output logic          dq_oe,
  output logic [NB-1:0] dqm_out,
  input  logic [DW-1:0] dq_in,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic [NB-1:0] rd_byte_vld
);

  logic [1:0] rst_sync_q;
  logic       core_rst_n;
  logic       beat_rd;
  logic       beat_wr;

  // Reset asserts at once and leaves on a clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  sdp_beat_seq u_seq (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .cfg_bl  (cfg_bl),
    .cmd_rd  (cmd_rd),
    .cmd_wr  (cmd_wr),
    .cmd_bst (cmd_bst),
    .beat_rd (beat_rd),
    .beat_wr (beat_wr)
  );

  sdp_pad_drive #(.DW(DW)) u_pad (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .beat_wr    (beat_wr),
    .wr_data_in (wr_data_in),
    .wr_mask_in (wr_mask_in),
    .rd_mask_in (rd_mask_in),
    .dq_out     (dq_out),
    .dqm_out    (dqm_out),
    .dq_oe      (dq_oe)
  );

  sdp_rd_capture #(.DW(DW)) u_cap (
    .clk         (clk),
    .rst_n       (core_rst_n),
    .cfg_cl3     (cfg_cl3),
    .beat_rd     (beat_rd),
    .dqm_pad     (dqm_out),
    .dq_in       (dq_in),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .rd_byte_vld (rd_byte_vld)
  );

  assign wr_take = beat_wr;

  AST_RD_LAT_CL2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!cfg_cl3 && $stable(cfg_cl3)) |-> (rd_valid == $past(beat_rd, 4))); // R4

  AST_RD_LAT_CL3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (cfg_cl3 && $stable(cfg_cl3)) |-> (rd_valid == $past(beat_rd, 5))); // R5

  AST_OE_CLEAR_OF_READ: assert property (@(posedge clk) disable iff (!core_rst_n)
    dq_oe |=> !rd_valid); // R10

endmodule

// File: tb/sdram_dq_path_tb_top.sv
module sdram_dq_path_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int NB = DW / 8;
  localparam int HIST = 4096;

  logic          clk;
  logic          rst_n;
  logic          cfg_cl3;
  logic [2:0]    cfg_bl;
  logic          cmd_rd, cmd_wr, cmd_bst;
  logic [DW-1:0] wr_data_in;
  logic [NB-1:0] wr_mask_in;
  logic          wr_take;
  logic [NB-1:0] rd_mask_in;
  logic [DW-1:0] dq_out;
  logic          dq_oe;
  logic [NB-1:0] dqm_out;
  logic [DW-1:0] dq_in;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [NB-1:0] rd_byte_vld;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  sdram_dq_path #(.DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cl3(cfg_cl3), .cfg_bl(cfg_bl),
    .cmd_rd(cmd_rd), .cmd_wr(cmd_wr), .cmd_bst(cmd_bst),
    .wr_data_in(wr_data_in), .wr_mask_in(wr_mask_in), .wr_take(wr_take),
    .rd_mask_in(rd_mask_in), .dq_out(dq_out), .dq_oe(dq_oe), .dqm_out(dqm_out),
    .dq_in(dq_in), .rd_valid(rd_valid), .rd_data(rd_data), .rd_byte_vld(rd_byte_vld)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  int            n = 0;
  bit            m_act = 0, m_wr = 0, m_page = 0;
  int            m_rem = 0;
  bit            cap_at [HIST];
  logic [NB-1:0] dqm_at [HIST];
  logic          e_oe = 0, e_rv = 0;
  logic [DW-1:0] e_dq = '0, e_rd = '0;
  logic [NB-1:0] e_dqm = '0, e_bv = '0;

  function automatic logic [DW-1:0] data_at(input int k);
    return DW'(k * 40503 + 7);
  endfunction

  function automatic int beats_of(input logic [2:0] c);
    case (c)
      3'd1: return 2;
      3'd2: return 4;
      3'd3: return 8;
      default: return 1;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at edge %0d: actual=%0h expected=%0h", tag, n, act, exp);
    end
  endtask

  function automatic bit write_ok();
    for (int k = 1; k <= 4; k++) if (cap_at[n + k]) return 0;
    return 1;
  endfunction

  task automatic step(input bit rd, input bit wr, input bit bst,
                      input logic [DW-1:0] wd, input logic [NB-1:0] wm,
                      input logic [NB-1:0] rm);
    bit newc, beat, bw;
    int cl;
    logic [NB-1:0] mk;
    @(negedge clk);
    cmd_rd = rd; cmd_wr = wr; cmd_bst = bst;
    wr_data_in = wd; wr_mask_in = wm; rd_mask_in = rm;
    dq_in = data_at(n);
    #1;
    newc = rd || wr;
    beat = newc || (m_act && !bst);
    bw   = newc ? wr : m_wr;
    chk(wr_take == (beat && bw), "R3/R8/R9 wr_take", wr_take, beat && bw);
    cl = cfg_cl3 ? 3 : 2;
    if (newc) begin
      m_page = (cfg_bl == 3'd7);
      m_rem  = beats_of(cfg_bl) - 1;
      m_act  = m_page || (m_rem > 0);
      m_wr   = wr;
    end else if (bst) begin
      m_act = 0;
    end else if (m_act && !m_page) begin
      m_rem--;
      m_act = (m_rem > 0);
    end
    dqm_at[n] = (beat && bw) ? wm : rm;
    e_oe  = beat && bw;
    e_dq  = e_oe ? wd : '0;
    e_dqm = dqm_at[n];
    if (beat && !bw) cap_at[n + 1 + cl] = 1;
    if (cap_at[n]) begin
      mk   = dqm_at[n - 3];
      e_rv = 1;
      e_bv = ~mk;
      for (int b = 0; b < NB; b++)
        e_rd[8*b +: 8] = mk[b] ? 8'h00 : dq_in[8*b +: 8];
    end else begin
      e_rv = 0;
      e_bv = '0;
    end
    @(posedge clk);
    #(CLK_PERIOD/4);
    chk(dq_oe == e_oe, "R2/R10 dq_oe", dq_oe, e_oe);
    chk(dq_out == e_dq, "R2/R11 dq_out", dq_out, e_dq);
    chk(dqm_out == e_dqm, "R11/R2 dqm_out", dqm_out, e_dqm);
    chk(rd_valid == e_rv, "R4/R5 rd_valid", rd_valid, e_rv);
    if (e_rv) chk(rd_data == e_rd, "R4/R7 rd_data", rd_data, e_rd);
    chk(rd_byte_vld == e_bv, "R6 rd_byte_vld", rd_byte_vld, e_bv);
    n++;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) step(0, 0, 0, '0, '0, '0);
  endtask

  task automatic rd_cmd(input logic [NB-1:0] rm);
    step(1, 0, 0, '0, '0, rm);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    finish_run();
  end

  initial begin
    rst_n = 0; cfg_cl3 = 0; cfg_bl = 3'd2;
    cmd_rd = 0; cmd_wr = 0; cmd_bst = 0;
    wr_data_in = '0; wr_mask_in = '0; rd_mask_in = '0; dq_in = '0;
    for (int i = 0; i < HIST; i++) begin cap_at[i] = 0; dqm_at[i] = '0; end
    repeat (3) @(posedge clk);
    #(CLK_PERIOD/4);
    // R1: reset state
    chk({dq_oe, rd_valid, wr_take} == 3'b000, "R1 control outputs in reset", {dq_oe, rd_valid, wr_take}, 0);
    chk(dq_out == '0 && dqm_out == '0 && rd_byte_vld == '0, "R1 data outputs in reset",
        {dq_out, dqm_out, rd_byte_vld}, 0);
    @(negedge clk);
    rst_n = 1;
    idle(4);

    // R4/R5: CL2, four-beat read, no masking
    cfg_cl3 = 0; cfg_bl = 3'd2;
    rd_cmd(2'b00); idle(8);
    // R6/R7: mask changing every beat
    rd_cmd(2'b01); step(0,0,0,'0,'0,2'b10); step(0,0,0,'0,'0,2'b11); step(0,0,0,'0,'0,2'b00);
    idle(8);
    // R5: CL3, eight-beat read with masks
    cfg_cl3 = 1; cfg_bl = 3'd3;
    rd_cmd(2'b10);
    for (int i = 0; i < 9; i++) step(0,0,0,'0,'0,NB'(i));
    idle(8);
    // R2/R7: four-beat write with per-beat masks
    cfg_bl = 3'd2;
    step(0,1,0,16'hA1B2,2'b00,2'b11); step(0,0,0,16'hC3D4,2'b01,2'b11);
    step(0,0,0,16'hE5F6,2'b10,2'b11); step(0,0,0,16'h0718,2'b11,2'b11);
    idle(4);
    // R3: single beat, two-beat write, reserved code
    cfg_bl = 3'd0; rd_cmd(2'b00); idle(8);
    cfg_bl = 3'd1; step(0,1,0,16'h1234,2'b01,2'b00); idle(4);
    cfg_bl = 3'd5; rd_cmd(2'b00); idle(8);
    // R9: read on every edge, each restarting
    cfg_cl3 = 0; cfg_bl = 3'd2;
    for (int i = 0; i < 5; i++) rd_cmd(NB'(i));
    idle(8);
    // R8: burst stop in the middle of an eight-beat read
    cfg_bl = 3'd3;
    rd_cmd(2'b00); idle(2); step(0,0,1,'0,'0,2'b00); idle(8);
    // R3/R8: full page runs until stopped
    cfg_bl = 3'd7;
    rd_cmd(2'b00); idle(20); step(0,0,1,'0,'0,2'b00); idle(8);
    // R9: write burst replaced by a read
    cfg_bl = 3'd3;
    step(0,1,0,16'h5555,2'b00,2'b00); step(0,0,0,16'h6666,2'b00,2'b00);
    rd_cmd(2'b01); idle(10);

    // Mixed random traffic under each latency
    for (int ph = 0; ph < 4; ph++) begin
      cfg_cl3 = ph[0];
      for (int c = 0; c < 500; c++) begin
        int r;
        logic [2:0] codes [6];
        codes = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd7};
        r = $urandom % 8;
        if (r < 3) cfg_bl = codes[$urandom % 6];
        if (r < 2)
          step(1, 0, 0, DW'($urandom), NB'($urandom), NB'($urandom));
        else if (r == 2 && write_ok())
          step(0, 1, 0, DW'($urandom), NB'($urandom), NB'($urandom));
        else if (r == 3)
          step(0, 0, 1, DW'($urandom), NB'($urandom), NB'($urandom));
        else
          step(0, 0, 0, DW'($urandom), NB'($urandom), NB'($urandom));
      end
      step(0, 0, 1, '0, '0, '0);
      idle(8);
    end

    finish_run();
  end

endmodule